// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Bank with Analog and Open-Drain Control

This block is an 8-pin bidirectional I/O bank. Software sees five byte registers on a simple bus: the pin readback, the output data latch, the per-pin direction, the per-pin analog-input select and the per-pin open-drain select. Toward the pads the block drives a per-pin output value and output enable, and it receives the raw pin level. Before the raw level reaches the readback register it passes through a two-stage synchronizer.

For each pin, four owners compete for the pad. They are checked in a fixed order, highest first:
1. A configuration override.
2. An analog output request.
3. Analog-input mode.
4. Digital drive from the latch, or from a remapped peripheral when that pin's peripheral enable is set.

Analog-input mode blanks the digital read of the pin but leaves its output driver untouched. An analog output releases the driver and blanks the read. The bus read data is combinational from the address. Writes take effect on the rising clock edge.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register is 0xFF, the latch is 0x00, the analog-select register is 0xFF, the open-drain register is 0x00, and no pad output enable is set.
- R2: A write to address 0 (port) or address 1 (latch) loads the written byte into the output latch on that clock edge. Address 1 then reads back the latch, whichever of the two addresses was written last.
- R3: A pin whose direction bit (address 2) is 0 enables its pad driver and drives its source value. A direction bit of 1 leaves the pad output enable at 0.
- R4: Reading address 0 returns the pad input levels as they were two rising edges earlier. A change on a pad input is not visible after only one edge.
- R5: A pin whose analog-select bit (address 3) is 1 reads as 0 at address 0. The bit has no effect on the pin's output enable or output value.
- R6: A pin whose open-drain bit (address 4) is 1 drives low with its enable set when its source value is 0. When its source value is 1 it has output enable 0. A pin whose open-drain bit is 0 drives push-pull.
- R7: A pin with its analog output request set, and no configuration override, has output enable 0 and reads as 0 at address 0, whatever its direction and latch bits are.
- R8: A pin with its configuration override set takes its pad output enable and value from the override inputs. This holds even while its analog output request is set.
- R9: A pin with its peripheral enable set uses the peripheral output bit instead of the latch bit as its source value. The direction and open-drain rules still apply to that value.
- R10: The register addresses are port 0, latch 1, direction 2, analog-select 3 and open-drain 4. Reads of addresses 5 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable, 1 drives |
| cfg_ovr_en | input | 8 | Per-pin configuration override select |
| cfg_ovr_out | input | 8 | Override output value |
| cfg_ovr_oe | input | 8 | Override output enable |
| ana_out_en | input | 8 | Per-pin analog output request |
| periph_en | input | 8 | Per-pin remapped peripheral select |
| periph_out | input | 8 | Peripheral output value |

## Verification
The registers feed the pad outputs combinationally. A wrong direction, open-drain or latch bit therefore shows on pad_oe or pad_out in the same cycle as the write edge. It also reads back wrongly at its own address straight away. A wrong synchronizer depth shows one edge too early or too late in the port readback, so the bench samples after exactly one edge and after exactly two edges following each pad change. An ownership error shows only when two owners are active together, so the tests pair each owner with the ones below it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PORT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ANS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ODC  = 3'd4;

  // Digital driver for one pin: open-drain drives only a low level.
  function automatic logic [1:0] drive_of(input logic dir_in, input logic odc,
                                          input logic src);
    logic oe, val;
    oe  = !dir_in && (!odc || !src);
    val = odc ? 1'b0 : src;
    return {oe, val};
  endfunction
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      port_view,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      lat_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      ans_q,
  output logic [W-1:0]      odc_q
);
  logic addr_hit;
  logic wr_lat_evt;
  assign addr_hit   = (bus_addr <= A_ODC);
  assign wr_lat_evt = bus_we && (bus_addr == A_PORT || bus_addr == A_LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      ans_q <= '1;
      odc_q <= '0;
    end else begin
      if (wr_lat_evt)                     lat_q <= bus_wdata;
      if (bus_we && bus_addr == A_DIR)    dir_q <= bus_wdata;
      if (bus_we && bus_addr == A_ANS)    ans_q <= bus_wdata;
      if (bus_we && bus_addr == A_ODC)    odc_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_PORT:  bus_rdata = port_view;
      A_LAT:   bus_rdata = lat_q;
      A_DIR:   bus_rdata = dir_q;
      A_ANS:   bus_rdata = ans_q;
      A_ODC:   bus_rdata = odc_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lat_evt |=> lat_q == $past(bus_wdata)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == '0); // R10
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_hit) |=> $stable(dir_q) && $stable(ans_q) && $stable(odc_q)); // R10
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

  AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q[0] == d |=> chain_q[1 % STAGES] == (STAGES > 1 ? $past(d) : d) || STAGES == 1); // R4
endmodule

// File: rtl/gpio_bank_pinmux.sv
module gpio_bank_pinmux
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] odc_q,
  input  logic [W-1:0] cfg_ovr_en,
  input  logic [W-1:0] cfg_ovr_out,
  input  logic [W-1:0] cfg_ovr_oe,
  input  logic [W-1:0] ana_out_en,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_out,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] src_bit;
  logic [W-1:0] dig_owner;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] drv;
    assign src_bit[i]   = periph_en[i] ? periph_out[i] : lat_q[i];
    assign dig_owner[i] = !cfg_ovr_en[i] && !ana_out_en[i];
    assign drv          = drive_of(dir_q[i], odc_q[i], src_bit[i]);

    always_comb begin
      if (cfg_ovr_en[i]) begin
        pad_oe[i]  = cfg_ovr_oe[i];
        pad_out[i] = cfg_ovr_out[i];
      end else if (ana_out_en[i]) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
      end else begin
        pad_oe[i]  = drv[1];
        pad_out[i] = drv[0];
      end
    end

    AST_ANA_OUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (ana_out_en[i] && !cfg_ovr_en[i]) |-> !pad_oe[i]); // R7
    AST_ODC_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_owner[i] && odc_q[i] && pad_oe[i]) |-> !pad_out[i]); // R6
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_owner[i] && dir_q[i]) |-> !pad_oe[i]); // R3
    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ovr_en[i] |-> (pad_oe[i] == cfg_ovr_oe[i] && pad_out[i] == cfg_ovr_out[i])); // R8
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W       = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      cfg_ovr_en,
  input  logic [W-1:0]      cfg_ovr_out,
  input  logic [W-1:0]      cfg_ovr_oe,
  input  logic [W-1:0]      ana_out_en,
  input  logic [W-1:0]      periph_en,
  input  logic [W-1:0]      periph_out
);
  logic [W-1:0] lat_q, dir_q, ans_q, odc_q;
  logic [W-1:0] pin_sync;
  logic [W-1:0] read_blank;
  logic [W-1:0] port_view;

  gpio_bank_sync #(.W(W), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  assign read_blank = ans_q | ana_out_en;
  assign port_view  = pin_sync & ~read_blank;

  gpio_bank_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .port_view(port_view), .bus_rdata(bus_rdata),
    .lat_q(lat_q), .dir_q(dir_q), .ans_q(ans_q), .odc_q(odc_q)
  );

  gpio_bank_pinmux #(.W(W)) u_mux (
    .clk(clk), .rst_n(rst_n), .lat_q(lat_q), .dir_q(dir_q), .odc_q(odc_q),
    .cfg_ovr_en(cfg_ovr_en), .cfg_ovr_out(cfg_ovr_out), .cfg_ovr_oe(cfg_ovr_oe),
    .ana_out_en(ana_out_en), .periph_en(periph_en), .periph_out(periph_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  AST_PORT_READ_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PORT) |-> (bus_rdata & (ans_q | ana_out_en)) == '0); // R5
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_out, pad_oe;
  logic [7:0] cfg_ovr_en = '0, cfg_ovr_out = '0, cfg_ovr_oe = '0;
  logic [7:0] ana_out_en = '0, periph_en = '0, periph_out = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .cfg_ovr_en(cfg_ovr_en),
    .cfg_ovr_out(cfg_ovr_out), .cfg_ovr_oe(cfg_ovr_oe), .ana_out_en(ana_out_en),
    .periph_en(periph_en), .periph_out(periph_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd2, v); check("R1 dir", v, 8'hFF);
    rd(3'd1, v); check("R1 lat", v, 8'h00);
    rd(3'd3, v); check("R1 ansel", v, 8'hFF);
    rd(3'd4, v); check("R1 odc", v, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(3'd1, 8'h3C); rd(3'd1, v); check("R2 latch write", v, 8'h3C);
    wr(3'd0, 8'hA5); rd(3'd1, v); check("R2 port write to latch", v, 8'hA5);
    wr(3'd4, 8'h00);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'h5A);
      rd(3'(a), v); check("R10 unmapped read", v, 8'h00);
    end
    rd(3'd2, v); check("R10 dir untouched", v, 8'hFF);
    rd(3'd3, v); check("R10 ansel untouched", v, 8'hFF);
    rd(3'd4, v); check("R10 odc untouched", v, 8'h00);
    rd(3'd1, v); check("R10 latch untouched", v, 8'hA5);
  endtask

  task automatic t_direction;
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'hF0);
    check("R3 oe low nibble", pad_oe, 8'h0F);
    check("R3 out low nibble", pad_out & pad_oe, 8'h05);
    check("R5 ansel keeps output", pad_out & 8'h0F, 8'h05);
    wr(3'd2, 8'hFF);
    check("R3 all inputs", pad_oe, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    wr(3'd3, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_addr = 3'd0;
    pad_in = 8'hC3;
    @(negedge clk); #1 check("R4 one edge old", bus_rdata, 8'h00);
    @(negedge clk); #1 check("R4 two edges new", bus_rdata, 8'hC3);
    pad_in = 8'h3C;
    @(negedge clk); #1 check("R4 one edge old b", bus_rdata, 8'hC3);
    @(negedge clk); #1 check("R4 two edges new b", bus_rdata, 8'h3C);
    wr(3'd3, 8'h0F);
    rd(3'd0, v); check("R5 ansel blanks read", v, 8'h30);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'hFF);
    check("R6 od oe", pad_oe, 8'h0F);
    check("R6 od out", pad_out, 8'h00);
    wr(3'd4, 8'h00);
    check("R6 push-pull oe", pad_oe, 8'hFF);
    check("R6 push-pull out", pad_out, 8'hF0);
  endtask

  task automatic t_analog_out;
    logic [7:0] v;
    pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    @(negedge clk);
    ana_out_en = 8'h81;
    rd(3'd0, v); check("R7 read blank", v, 8'h7E);
    check("R7 driver off", pad_oe, 8'h7E);
    ana_out_en = 8'h00;
  endtask

  task automatic t_override;
    @(negedge clk);
    ana_out_en = 8'h03; cfg_ovr_en = 8'h01; cfg_ovr_oe = 8'h01; cfg_ovr_out = 8'h01;
    #1 check("R8 ovr beats analog oe", pad_oe, 8'hFC | 8'h01);
    check("R8 ovr value", pad_out & 8'h03, 8'h01);
    cfg_ovr_oe = 8'h00;
    #1 check("R8 ovr release", pad_oe & 8'h03, 8'h00);
    ana_out_en = 8'h00; cfg_ovr_en = 8'h00;
  endtask

  task automatic t_periph;
    wr(3'd1, 8'h00);
    @(negedge clk);
    periph_en = 8'h0F; periph_out = 8'h0A;
    #1 check("R9 periph value", pad_out, 8'h0A);
    wr(3'd4, 8'h0F);
    check("R9 periph open-drain oe", pad_oe, 8'hF5);
    check("R9 periph open-drain out", pad_out, 8'h00);
    wr(3'd2, 8'h0F);
    check("R9 periph dir input", pad_oe, 8'hF0);
    periph_en = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_direction();
    t_sync();
    t_open_drain();
    t_analog_out();
    t_override();
    t_periph();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule